// File: doc/BRIEF.md
# Transmit Completion Status Queue

This block keeps a short record of finished transmissions, one status byte each, so that the host can read why each frame ended. The transmit engine raises a completion event with three error flags (jabber, underrun, excessive collisions) and a flag that asks for a report even on success. Events that carry an error, or that ask for a report, turn into an entry. The host sees the oldest entry on `top_o` and discards it by any write to the status port, signalled here by `pop_i`.

While any entry is held, the TX-complete interrupt source `irq_o` is high. If an event arrives when every slot is taken, the event is dropped and the overflow bit is set in the entry the host will read next. A jabber or underrun is fatal: `tx_en_o` falls and stays low until the TX reset command `tx_reset_i`, which also empties the queue.

Top module: `tx_cmpl_stack`

## Requirements
- R1: An entry byte has bit 7 = 1 (complete), bit 6 = report-requested flag, bit 5 = jabber, bit 4 = underrun, bit 3 = excessive collisions, bit 2 = overflow; bits 1 and 0 are always 0.
- R2: An event with no error flag stores an entry (0xC0) only when its report-requested flag is set; otherwise nothing changes.
- R3: An event with any error flag always stores an entry, whatever its report-requested flag.
- R4: `top_o` shows the oldest held entry, entries leave in arrival order, and `top_o` reads 0x00 when the queue is empty.
- R5: `pop_i` on a non-empty queue removes the oldest entry on that clock edge; `pop_i` on an empty queue has no effect.
- R6: `irq_o` is high exactly while at least one entry is held.
- R7: With all DEPTH slots held and no pop in the same cycle, an event that would store an entry is dropped and bit 2 of the oldest entry is set; the other entries are unchanged.
- R8: An event with jabber or underrun drives `tx_en_o` low from the next cycle, and it stays low through later events and pops.
- R9: `tx_reset_i` empties the queue and sets `tx_en_o` high on the next edge, taking priority over an event or pop in the same cycle.
- R10: An event and a pop in the same cycle on a full queue remove the oldest entry and store the new one, with no overflow mark.
- R11: After reset the queue is empty (`top_o` = 0x00, `irq_o` = 0) and `tx_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Transmission finished this cycle |
| evt_jabber_i | input | 1 | Finished with jabber error (fatal) |
| evt_underrun_i | input | 1 | Finished with underrun (fatal) |
| evt_maxcoll_i | input | 1 | Finished after too many collisions |
| evt_rpt_req_i | input | 1 | Report requested even on success |
| pop_i | input | 1 | Host write to the status port |
| tx_reset_i | input | 1 | TX reset command |
| top_o | output | 8 | Oldest entry, 0x00 when empty |
| irq_o | output | 1 | TX-complete interrupt source |
| tx_en_o | output | 1 | Transmitter allowed to run |

## Verification
Two functions meet in one cycle: a host pop and a new completion event, most sharply when the queue is full, where the pop must make room instead of the event being counted as an overflow. The bench fills all slots, then issues an event and a pop on the same edge and reads the queue out, expecting the new entry at the tail and no overflow bit anywhere. A TX reset is also raised together with a fatal event to confirm the reset wins, and a pop together with an event on an empty queue is checked to keep the event.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int BIT_DONE = 7;
  localparam int BIT_RPT  = 6;
  localparam int BIT_JAB  = 5;
  localparam int BIT_UND  = 4;
  localparam int BIT_COLL = 3;
  localparam int BIT_OVF  = 2;

  typedef struct packed {
    logic jabber;
    logic underrun;
    logic maxcoll;
    logic rpt_req;
  } evt_t;

  function automatic logic [7:0] make_entry(evt_t e);
    logic [7:0] b;
    b = '0;
    b[BIT_DONE] = 1'b1;
    b[BIT_RPT]  = e.rpt_req;
    b[BIT_JAB]  = e.jabber;
    b[BIT_UND]  = e.underrun;
    b[BIT_COLL] = e.maxcoll;
    return b;
  endfunction
endpackage

// File: rtl/tcs_encode.sv
module tcs_encode
  import tcs_pkg::*;
(
  input  logic       valid_i,
  input  evt_t       evt_i,
  output logic       push_o,
  output logic       fatal_o,
  output logic [7:0] entry_o
);
  logic any_err;
  assign any_err = evt_i.jabber | evt_i.underrun | evt_i.maxcoll;
  assign push_o  = valid_i & (any_err | evt_i.rpt_req);
  assign fatal_o = valid_i & (evt_i.jabber | evt_i.underrun);
  assign entry_o = make_entry(evt_i);

  always_comb begin
    // R3
    err_push_chk: assert (!(valid_i && any_err) || push_o);
  end
endmodule

// File: rtl/tcs_lock.sv
module tcs_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fatal_i,
  input  logic clr_i,
  output logic tx_en_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      locked_q <= 1'b0;
    else if (clr_i)   locked_q <= 1'b0;
    else if (fatal_i) locked_q <= 1'b1;
  end

  assign tx_en_o = ~locked_q;

  // R8
  fatal_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fatal_i && !clr_i) |=> !tx_en_o);
  // R8
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_o && !clr_i) |=> !tx_en_o);
  // R9
  reset_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> tx_en_o);
endmodule

// File: rtl/tcs_store.sv
module tcs_store
  import tcs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       push_i,
  input  logic [7:0] data_i,
  input  logic       pop_i,
  output logic [7:0] top_o,
  output logic       empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop, do_push, do_drop, full;

  assign full    = (cnt_q == FULL);
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full | do_pop);
  assign do_drop = push_i & ~do_push;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (!clr_i) begin
        if (do_push && wr_q == PTR_W'(g))      mem_q[g] <= data_i;
        else if (do_drop && rd_q == PTR_W'(g)) mem_q[g][BIT_OVF] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign top_o = empty_o ? 8'h00 : mem_q[rd_q];

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  // R7
  drop_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !clr_i) |=> (top_o[BIT_OVF] && full));
  // R5
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !clr_i) |=> empty_o);
  // R9
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/tx_cmpl_stack.sv
module tx_cmpl_stack
  import tcs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_valid_i,
  input  logic       evt_jabber_i,
  input  logic       evt_underrun_i,
  input  logic       evt_maxcoll_i,
  input  logic       evt_rpt_req_i,
  input  logic       pop_i,
  input  logic       tx_reset_i,
  output logic [7:0] top_o,
  output logic       irq_o,
  output logic       tx_en_o
);
  evt_t       evt;
  logic       push, fatal, empty;
  logic [7:0] entry;

  assign evt = '{jabber: evt_jabber_i, underrun: evt_underrun_i,
                 maxcoll: evt_maxcoll_i, rpt_req: evt_rpt_req_i};

  tcs_encode u_enc (
    .valid_i (evt_valid_i),
    .evt_i   (evt),
    .push_o  (push),
    .fatal_o (fatal),
    .entry_o (entry)
  );

  tcs_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tx_reset_i),
    .push_i  (push),
    .data_i  (entry),
    .pop_i   (pop_i),
    .top_o   (top_o),
    .empty_o (empty)
  );

  tcs_lock u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fatal_i (fatal),
    .clr_i   (tx_reset_i),
    .tx_en_o (tx_en_o)
  );

  assign irq_o = ~empty;

  // R6
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == top_o[BIT_DONE]);
  // R1
  low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_o[1:0] == 2'b00);
endmodule

// File: tb/tb_tx_cmpl_stack.sv
module tb_tx_cmpl_stack;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       v = 0, jab = 0, und = 0, col = 0, rpt = 0, pop = 0, trst = 0;
  logic [7:0] top;
  logic       irq, tx_en;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  tx_cmpl_stack #(.DEPTH(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(v), .evt_jabber_i(jab),
    .evt_underrun_i(und), .evt_maxcoll_i(col), .evt_rpt_req_i(rpt),
    .pop_i(pop), .tx_reset_i(trst), .top_o(top), .irq_o(irq), .tx_en_o(tx_en)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; returns at the following negedge
  task automatic cyc(bit ev, bit j, bit u, bit c, bit r, bit p, bit t);
    v = ev; jab = j; und = u; col = c; rpt = r; pop = p; trst = t;
    @(negedge clk);
    v = 0; jab = 0; und = 0; col = 0; rpt = 0; pop = 0; trst = 0;
  endtask

  task automatic fill4();
    cyc(1,0,0,1,0,0,0);
    cyc(1,0,0,0,1,0,0);
    cyc(1,0,0,0,1,0,0);
    cyc(1,0,0,0,1,0,0);
  endtask

  task automatic t_reset();
    chk("R11 top", top, 8'h00);
    chk("R11 irq", irq, 0);
    chk("R11 tx_en", tx_en, 1);
  endtask

  task automatic t_format();
    cyc(1,0,0,0,1,0,0);
    chk("R2 rpt success", top, 8'hC0);
    chk("R6 irq set", irq, 1);
    cyc(0,0,0,0,0,1,0);
    chk("R5 pop", top, 8'h00);
    chk("R6 irq clr", irq, 0);
    cyc(1,0,0,0,0,0,0);
    chk("R2 silent success", top, 8'h00);
    chk("R2 irq", irq, 0);
    cyc(1,0,0,1,1,0,0);
    chk("R1 coll+rpt", top, 8'hC8);
    cyc(0,0,0,0,0,1,0);
    cyc(1,0,0,1,0,0,0);
    chk("R3 coll no rpt", top, 8'h88);
    cyc(0,0,0,0,0,1,0);
  endtask

  task automatic t_order();
    cyc(1,0,0,1,0,0,0);
    cyc(1,0,0,0,1,0,0);
    chk("R4 oldest", top, 8'h88);
    cyc(0,0,0,0,0,1,0);
    chk("R4 next", top, 8'hC0);
    cyc(0,0,0,0,0,1,0);
    chk("R4 empty", top, 8'h00);
    cyc(0,0,0,0,0,1,0);
    chk("R5 empty pop top", top, 8'h00);
    chk("R5 empty pop irq", irq, 0);
    cyc(1,0,0,0,1,1,0);
    chk("R5 pop+evt on empty", top, 8'hC0);
    cyc(0,0,0,0,0,1,0);
  endtask

  task automatic t_overflow();
    fill4();
    cyc(1,0,0,1,0,0,0);
    chk("R7 ovf mark", top, 8'h8C);
    cyc(0,0,0,0,0,1,0);
    chk("R7 e2", top, 8'hC0);
    cyc(0,0,0,0,0,1,0);
    chk("R7 e3", top, 8'hC0);
    cyc(0,0,0,0,0,1,0);
    chk("R7 e4", top, 8'hC0);
    cyc(0,0,0,0,0,1,0);
    chk("R7 dropped", top, 8'h00);
  endtask

  task automatic t_lock();
    cyc(1,1,0,0,0,0,0);
    chk("R8 jabber lock", tx_en, 0);
    chk("R1 jabber entry", top, 8'hA0);
    cyc(1,0,0,1,0,0,0);
    cyc(0,0,0,0,0,1,0);
    chk("R8 lock held", tx_en, 0);
    cyc(0,0,0,0,0,0,1);
    chk("R9 unlock", tx_en, 1);
    chk("R9 empty", top, 8'h00);
    chk("R9 irq", irq, 0);
    cyc(1,0,1,0,1,0,0);
    chk("R1 underrun entry", top, 8'hD0);
    chk("R8 underrun lock", tx_en, 0);
    cyc(1,1,0,0,0,1,1);
    chk("R9 prio tx_en", tx_en, 1);
    chk("R9 prio empty", top, 8'h00);
  endtask

  task automatic t_same();
    fill4();
    cyc(1,0,0,1,0,1,0);
    chk("R10 head", top, 8'hC0);
    cyc(0,0,0,0,0,1,0);
    cyc(0,0,0,0,0,1,0);
    chk("R10 third", top, 8'hC0);
    cyc(0,0,0,0,0,1,0);
    chk("R10 tail no ovf", top, 8'h88);
    cyc(0,0,0,0,0,1,0);
    chk("R10 drained", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_format();
    t_order();
    t_overflow();
    t_lock();
    t_same();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule